// File: doc/BRIEF.md
# I2C Slave with Pointer-Addressed Byte Buffer

This block connects a small on-chip byte buffer to an I2C bus so that an external master can fill it and read it back without any local processor handling individual bytes. The slave matches its own 7-bit address in hardware. The buffer holds 32 bytes and is indexed by a 5-bit pointer.

Every write transaction begins by naming a location. The first data byte after the address byte is latched as the base pointer. A separate running pointer starts at that base and steps up by one for each further byte written. A read transaction, entered with a Start or a repeated Start, always begins at the latched base pointer and steps forward while the master keeps acknowledging. Two status outputs show whether a transaction addressed to this slave is in progress and which way it flows. A synchronous local read port lets the surrounding logic inspect the buffer.

The bus-side state machine has these states: IDLE, ADDR (shifting in the address byte), ADDR_ACK, RX_PTR (shifting in the pointer byte), PTR_ACK, RX_DATA, DATA_ACK, TX_DATA (shifting out a buffer byte), TX_ACKCHK (sampling the master's acknowledge) and WAIT (ignoring the bus). A Stop moves any state to IDLE, and a Start or repeated Start moves any state to ADDR. The remaining transitions all happen on a falling SCL edge that follows a complete byte or a complete acknowledge bit:
- ADDR goes to ADDR_ACK on a match and to WAIT otherwise.
- ADDR_ACK goes to TX_DATA for a read and to RX_PTR for a write.
- RX_PTR goes to PTR_ACK, and PTR_ACK goes to RX_DATA.
- RX_DATA and DATA_ACK alternate.
- TX_DATA goes to TX_ACKCHK.
- TX_ACKCHK goes back to TX_DATA if the master acknowledged, and to WAIT if it did not.

Top module: `i2c_ptr_slave`

## Requirements
- R1: The slave pulls SDA low during the ninth clock only for an address byte whose upper seven bits equal `own_addr`. For any other address it acknowledges neither that byte nor any later byte until the next Start, and it writes nothing to the buffer.
- R2: In a write, the low five bits of the first data byte become the base pointer, and that byte is acknowledged. Bits 7..5 of the byte are ignored.
- R3: The bytes that follow in the same write are each acknowledged and stored at the base pointer, base+1, base+2 and so on.
- R4: The running pointer wraps from 31 to 0, for both writes and reads.
- R5: A read, whether after a Start or a repeated Start, returns the byte at the base pointer first, sent MSB first. Each byte the master acknowledges is followed by the next location.
- R6: A read never changes the base pointer, so back-to-back reads start at the same location.
- R7: After the master does not acknowledge a read byte, the slave leaves SDA released until the next Start or Stop.
- R8: `busy` rises when the address matches and falls on the next Stop. A non-matching address leaves it low.
- R9: While `busy` is high, `dir_read` is 1 for a master read and 0 for a master write.
- R10: `loc_rd_data` equals the buffer byte at `loc_rd_addr` one clock after the address is presented. When the bus writes that same location on the same clock, the port shows the old byte first and then the new byte.
- R11: After reset, `busy`, `dir_read` and `sda_drive_low` are 0 and every buffer byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND of all drivers) |
| sda_drive_low | output | 1 | 1 pulls SDA low; 0 releases it |
| own_addr | input | 7 | This slave's bus address |
| loc_rd_addr | input | 5 | Local read port location |
| loc_rd_data | output | 8 | Local read port data, one clock latency |
| busy | output | 1 | An addressed transaction is open |
| dir_read | output | 1 | 1 for a master read, 0 for a master write |

## Verification
A bus write into a buffer location and a local-port read of that same location can land on the same clock. The bench holds `loc_rd_addr` on the target location while the master writes a single byte there, and it samples the port on every clock of the transaction. The run is judged correct only if every sample is either the old byte or the new byte, never anything else, and if the new byte is present once the Stop has been sent.

// File: rtl/i2c_ptr_pkg.sv
package i2c_ptr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX_PTR,
        ST_PTR_ACK,
        ST_RX_DATA,
        ST_DATA_ACK,
        ST_TX_DATA,
        ST_TX_ACKCHK,
        ST_WAIT
    } slv_state_t;

endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    logic [SYNC_STAGES-1:0] scl_chain;
    logic [SYNC_STAGES-1:0] sda_chain;
    logic                   scl_q;
    logic                   sda_q;

    generate
        if (SYNC_STAGES > 1) begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_chain <= '1;
                    sda_chain <= '1;
                end else begin
                    scl_chain <= {scl_chain[SYNC_STAGES-2:0], scl_i};
                    sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_i};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_chain <= '1;
                    sda_chain <= '1;
                end else begin
                    scl_chain <= scl_i;
                    sda_chain <= sda_i;
                end
            end
        end
    endgenerate

    assign scl_s = scl_chain[SYNC_STAGES-1];
    assign sda_s = sda_chain[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // A Start or a Stop is an SDA edge seen while SCL stays high.
    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_byte_store.sv
module i2c_byte_store #(
    parameter int PTR_W  = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  bus_raddr,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PTR_W-1:0]  loc_raddr,
    output logic [DATA_W-1:0] loc_rdata
);

    localparam int DEPTH = 1 << PTR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // The bus side reads without a register, because a byte must be ready
    // on the same SCL fall that starts sending it.
    assign bus_rdata = cells[bus_raddr];

    // The local port is registered, so it sees the contents from before
    // any write made on the same clock.
    always_ff @(posedge clk) begin
        if (!rst_n) loc_rdata <= '0;
        else        loc_rdata <= cells[loc_raddr];
    end

endmodule

// File: rtl/i2c_ptr_slave.sv
module i2c_ptr_slave
    import i2c_ptr_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int PTR_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_drive_low,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [PTR_W-1:0]  loc_rd_addr,
    output logic [7:0]        loc_rd_data,
    output logic              busy,
    output logic              dir_read
);

    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    slv_state_t        state, nxt;
    logic              scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic [CNT_W-1:0]  bit_cnt;
    logic [PTR_W-1:0]  base_ptr;
    logic [PTR_W-1:0]  cur_ptr;
    logic              busy_q, dir_q, mack_q;
    logic              buf_we;
    logic [7:0]        bus_rdata;
    logic              byte_done, tx_last, addr_hit, rx_state, ack_state;

    i2c_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    i2c_byte_store #(.PTR_W(PTR_W), .DATA_W(8)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (buf_we),
        .waddr     (cur_ptr),
        .wdata     (rx_sh[7:0]),
        .bus_raddr (cur_ptr),
        .bus_rdata (bus_rdata),
        .loc_raddr (loc_rd_addr),
        .loc_rdata (loc_rd_data)
    );

    assign byte_done = (bit_cnt == CNT_W'(BYTE_W));
    assign tx_last   = (bit_cnt == CNT_W'(BYTE_W - 1));
    assign addr_hit  = (rx_sh[BYTE_W-1:1] == own_addr);
    assign rx_state  = (state == ST_ADDR) || (state == ST_RX_PTR) || (state == ST_RX_DATA);
    assign ack_state = (state == ST_ADDR_ACK) || (state == ST_PTR_ACK) ||
                       (state == ST_DATA_ACK) || (state == ST_TX_ACKCHK);
    assign buf_we    = (state == ST_RX_DATA) && scl_fall && byte_done;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        if (stop_ev) begin
            nxt = ST_IDLE;
        end else if (start_ev) begin
            nxt = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_ADDR:      if (scl_fall && byte_done) nxt = addr_hit ? ST_ADDR_ACK : ST_WAIT;
                ST_ADDR_ACK:  if (scl_fall) nxt = dir_q ? ST_TX_DATA : ST_RX_PTR;
                ST_RX_PTR:    if (scl_fall && byte_done) nxt = ST_PTR_ACK;
                ST_PTR_ACK:   if (scl_fall) nxt = ST_RX_DATA;
                ST_RX_DATA:   if (scl_fall && byte_done) nxt = ST_DATA_ACK;
                ST_DATA_ACK:  if (scl_fall) nxt = ST_RX_DATA;
                ST_TX_DATA:   if (scl_fall && tx_last) nxt = ST_TX_ACKCHK;
                ST_TX_ACKCHK: if (scl_fall) nxt = mack_q ? ST_TX_DATA : ST_WAIT;
                ST_WAIT:      nxt = ST_WAIT;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    // Datapath: shifters, bit counter, pointers and status flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh    <= '0;
            tx_sh    <= '1;
            bit_cnt  <= '0;
            base_ptr <= '0;
            cur_ptr  <= '0;
            busy_q   <= 1'b0;
            dir_q    <= 1'b0;
            mack_q   <= 1'b0;
        end else if (stop_ev) begin
            busy_q  <= 1'b0;
            bit_cnt <= '0;
        end else if (start_ev) begin
            bit_cnt <= '0;
        end else begin
            if (rx_state && scl_rise) begin
                rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (state == ST_TX_ACKCHK && scl_rise) begin
                mack_q <= ~sda_s;
            end
            if (scl_fall) begin
                if (ack_state) bit_cnt <= '0;
                unique case (state)
                    ST_ADDR: begin
                        if (byte_done && addr_hit) begin
                            busy_q <= 1'b1;
                            dir_q  <= rx_sh[0];
                            if (rx_sh[0]) cur_ptr <= base_ptr;
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (dir_q) tx_sh <= bus_rdata;
                    end
                    ST_RX_PTR: begin
                        if (byte_done) begin
                            base_ptr <= rx_sh[PTR_W-1:0];
                            cur_ptr  <= rx_sh[PTR_W-1:0];
                        end
                    end
                    ST_RX_DATA: begin
                        if (byte_done) cur_ptr <= cur_ptr + 1'b1;
                    end
                    ST_TX_DATA: begin
                        tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b1};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (tx_last) cur_ptr <= cur_ptr + 1'b1;
                    end
                    ST_TX_ACKCHK: begin
                        if (mack_q) tx_sh <= bus_rdata;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        sda_drive_low = 1'b0;
        unique case (state)
            ST_ADDR_ACK, ST_PTR_ACK, ST_DATA_ACK: sda_drive_low = 1'b1;
            ST_TX_DATA:                           sda_drive_low = ~tx_sh[BYTE_W-1];
            default:                              sda_drive_low = 1'b0;
        endcase
        busy     = busy_q;
        dir_read = dir_q;
    end

endmodule

// File: rtl/i2c_ptr_slave_chk.sv
module i2c_ptr_slave_chk
    import i2c_ptr_pkg::*;
#(
    parameter int PTR_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input slv_state_t       state,
    input logic             scl_s,
    input logic             stop_ev,
    input logic             sda_drive_low,
    input logic             busy,
    input logic             dir_read,
    input logic [PTR_W-1:0] base_ptr,
    input logic [PTR_W-1:0] cur_ptr
);

    // SDA only ever changes while SCL is low, so the slave never forms a Start or a Stop.
    assert_sda_moves_scl_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_drive_low) |-> !scl_s);

    // The base pointer is loaded only from the first byte of a write.
    assert_base_only_from_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(base_ptr) |-> $past(state) == ST_RX_PTR);

    // While moving data, the running pointer only steps by one, modulo the depth.
    assert_ptr_step_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cur_ptr) && ($past(state) == ST_RX_DATA || $past(state) == ST_TX_DATA))
        |-> cur_ptr == PTR_W'($past(cur_ptr) + 1'b1));

    // After a master NACK the slave releases SDA.
    assert_release_after_nack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_TX_ACKCHK && state == ST_WAIT) |-> !sda_drive_low);

    // busy rises only out of the address phase.
    assert_busy_rise_on_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(state) == ST_ADDR);

    // busy falls only on a Stop, and a Stop always clears it.
    assert_busy_clear_on_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !busy);

    assert_busy_fall_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(stop_ev));

    // The direction flag is taken from the address byte only.
    assert_dir_from_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dir_read) |-> $past(state) == ST_ADDR);

endmodule

bind i2c_ptr_slave i2c_ptr_slave_chk #(.PTR_W(PTR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .state         (state),
    .scl_s         (scl_s),
    .stop_ev       (stop_ev),
    .sda_drive_low (sda_drive_low),
    .busy          (busy),
    .dir_read      (dir_read),
    .base_ptr      (base_ptr),
    .cur_ptr       (cur_ptr)
);

// File: tb/sim_i2c_ptr_slave.sv
`timescale 1ns/1ps
module sim_i2c_ptr_slave;

    localparam int H = 10;
    localparam logic [6:0] MY_ADDR = 7'h5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_low = 1'b0;
    logic [6:0] own_addr = MY_ADDR;
    logic [4:0] loc_rd_addr = '0;
    logic [7:0] loc_rd_data;
    logic       sda_drive_low, busy, dir_read;
    logic       sda_bus;

    assign sda_bus = ~(m_low | sda_drive_low);

    i2c_ptr_slave u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (m_scl),
        .sda_i         (sda_bus),
        .sda_drive_low (sda_drive_low),
        .own_addr      (own_addr),
        .loc_rd_addr   (loc_rd_addr),
        .loc_rd_data   (loc_rd_data),
        .busy          (busy),
        .dir_read      (dir_read)
    );

    always #5 clk = ~clk;

    int         errs = 0;
    int         chks = 0;
    bit         done = 0;
    logic [7:0] mem [32];
    logic [4:0] base = '0;

    bit         mon_on = 0;
    bit         mon_bad = 0;
    logic [7:0] mon_old, mon_new;

    always @(negedge clk) begin
        if (mon_on && loc_rd_data !== mon_old && loc_rd_data !== mon_new) mon_bad = 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        chks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pattern(input int s, input int k);
        return 8'((s * 29 + k * 53 + 7) & 255);
    endfunction

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 0; wt(H);
        m_scl = 1; wt(H);
        m_low = 1; wt(H);
        m_scl = 0; wt(H);
    endtask

    task automatic bus_stop();
        m_low = 1; wt(H);
        m_scl = 1; wt(H);
        m_low = 0; wt(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; wt(H);
            m_scl = 1; wt(H);
            m_scl = 0;
        end
        m_low = 0; wt(H);
        m_scl = 1; wt(H / 2);
        ack = (sda_bus == 1'b0);
        wt(H / 2);
        m_scl = 0; wt(H);
    endtask

    task automatic recv_byte(input bit nack, output logic [7:0] b);
        m_low = 0;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            wt(H);
            m_scl = 1; wt(H / 2);
            b = {b[6:0], sda_bus};
            wt(H / 2);
            m_scl = 0;
        end
        wt(1);
        m_low = ~nack; wt(H);
        m_scl = 1; wt(H);
        m_scl = 0; wt(1);
        m_low = 0; wt(H);
    endtask

    task automatic loc_read(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk) loc_rd_addr = a;
        @(negedge clk) d = loc_rd_data;
    endtask

    task automatic write_burst(input logic [7:0] ptr_byte, input int n, input int seed);
        bit ack;
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack);
        check("R1 write address ack", ack, 1);
        check("R8 busy after match", busy, 1);
        check("R9 dir on write", dir_read, 0);
        send_byte(ptr_byte, ack);
        check("R2 pointer byte ack", ack, 1);
        base = ptr_byte[4:0];
        for (int k = 0; k < n; k++) begin
            send_byte(pattern(seed, k), ack);
            check("R3 data byte ack", ack, 1);
            mem[5'(base + k)] = pattern(seed, k);
        end
        bus_stop();
        check("R8 busy cleared by stop", busy, 0);
    endtask

    task automatic read_burst(input int n, input string tag);
        bit ack;
        logic [7:0] d;
        bus_start();
        send_byte({MY_ADDR, 1'b1}, ack);
        check("R1 read address ack", ack, 1);
        check("R9 dir on read", dir_read, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k == n - 1, d);
            check(tag, d, mem[5'(base + k)]);
        end
        // The master keeps clocking after its NACK; the line must stay high.
        for (int j = 0; j < 3; j++) begin
            wt(H); m_scl = 1; wt(H / 2);
            check("R7 released after nack", sda_bus, 1);
            wt(H / 2); m_scl = 0;
        end
        wt(H);
        bus_stop();
        check("R8 busy cleared by stop", busy, 0);
    endtask

    task automatic verify_all(input string tag);
        logic [7:0] d;
        for (int i = 0; i < 32; i++) begin
            loc_read(5'(i), d);
            check(tag, d, mem[i]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, chks);
            $finish;
        end
    end

    initial begin
        bit ack;
        logic [7:0] d;
        for (int i = 0; i < 32; i++) mem[i] = '0;
        wt(4);
        rst_n = 1;
        wt(4);

        // R11: reset state
        check("R11 busy after reset", busy, 0);
        check("R11 dir after reset", dir_read, 0);
        check("R11 sda released after reset", sda_drive_low, 0);
        verify_all("R11 buffer cleared");

        // R1 / R8: every 7-bit address against the programmed one
        for (int a = 0; a < 128; a++) begin
            bus_start();
            send_byte({7'(a), 1'b0}, ack);
            check("R1 address compare", ack, (7'(a) == MY_ADDR) ? 1 : 0);
            check("R8 busy follows match", busy, (7'(a) == MY_ADDR) ? 1 : 0);
            bus_stop();
        end

        // R3 / R10: fill the whole buffer from location 0
        write_burst(8'h00, 32, 1);
        verify_all("R3 R10 full buffer write");

        // R4: write that wraps past location 31
        write_burst(8'h1E, 4, 2);
        verify_all("R4 write wrap");

        // R5 / R4: read from base 30 across the wrap, then R6 repeat
        read_burst(5, "R5 R4 read from base with wrap");
        read_burst(3, "R6 base unchanged by read");

        // R2: pointer-only write, upper bits of the pointer byte ignored
        write_burst(8'hE3, 0, 3);
        read_burst(2, "R2 base from pointer byte");

        // R5: repeated Start turns a pointer write into a read
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack);
        send_byte(8'h0A, ack);
        base = 5'h0A;
        bus_start();
        send_byte({MY_ADDR, 1'b1}, ack);
        check("R5 ack after repeated start", ack, 1);
        check("R9 dir after repeated start", dir_read, 1);
        recv_byte(0, d);
        check("R5 repeated start first byte", d, mem[10]);
        recv_byte(1, d);
        check("R5 repeated start second byte", d, mem[11]);
        wt(H);
        bus_stop();

        // R1: data after a foreign address is neither acknowledged nor stored
        bus_start();
        send_byte({MY_ADDR ^ 7'h01, 1'b0}, ack);
        check("R1 foreign address nack", ack, 0);
        send_byte(8'h03, ack);
        check("R1 foreign pointer ignored", ack, 0);
        send_byte(8'h77, ack);
        check("R1 foreign data ignored", ack, 0);
        check("R8 busy low for foreign", busy, 0);
        bus_stop();
        verify_all("R1 buffer unchanged by foreign write");

        // R10: local read of a location while the bus writes it
        loc_rd_addr = 5'd7;
        wt(2);
        mon_old = mem[7];
        mon_new = pattern(9, 0);
        mon_on = 1;
        write_burst(8'h07, 1, 9);
        wt(2);
        mon_on = 0;
        check("R10 collision only old or new seen", mon_bad, 0);
        check("R10 collision final value", loc_rd_data, mon_new);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, chks);
        $finish;
    end

endmodule